// File: doc/BRIEF.md
# Guarded Inter-Context Call Unit

This block sequences calls that cross from one execution context into another on a multithreaded core. It supports three operations: a guarded call, an entry handshake executed by the callee, and a return. A call names a target address and a target context. It completes only when two conditions hold. The address must fall inside the callable window of the target context, and the instruction word fetched at that address must be the dedicated entry opcode. The block never touches the general registers, so parameters travel in registers unchanged.

For every completed call the block saves a record holding the return PC and the caller's thread, process and context numbers. The record goes onto a stack that belongs to the calling process and that software can neither read nor write. Each process stack has a pointer, a base and a limit. A call is refused when the pointer equals the limit, and a return is refused when the pointer equals the base. The entry operation hands the callee the thread and process numbers of its most recent caller, so software can apply its own admission policy.

Top module: `ctx_call_unit`

## Requirements
- R1: A call (op_kind 2'b01) that raises no fault produces, one cycle later, a one-cycle out_valid pulse with out_pc equal to the target address, out_cid equal to the target context, and out_tid/out_pid equal to the caller's thread and process.
- R2: Each context has an inclusive callable window lo..hi, reset to 16'h0000..16'hFFFF and written through cfg_sel 2'b00 (lo) and 2'b01 (hi) with cfg_idx as context number. A call whose target lies outside the window faults with code 2'b01.
- R3: A call whose target is inside the window but whose tgt_opcode differs from ENTRY_OP (default 16'hE7A0) faults with code 2'b10. The window check takes priority over the opcode check.
- R4: A call that passes both checks while the caller's stack pointer equals its limit faults with code 2'b11 (overflow).
- R5: A faulting call pushes nothing and leaves out_pc and out_cid unchanged; it gives a one-cycle flt_valid pulse with the code on flt_code.
- R6: A return (op_kind 2'b11) pops the caller process's most recent record last-in-first-out and presents its PC, context, thread and process on out_pc, out_cid, out_tid and out_pid with an out_valid pulse one cycle later.
- R7: A return while the process stack pointer equals its base faults with code 2'b11 (underflow).
- R8: An entry (op_kind 2'b10) produces an ent_valid pulse carrying the thread and process numbers of the newest record on the current process's stack, without moving out_pc. An entry on an empty stack faults with code 2'b11.
- R9: Each process (cur_pid) has its own stack; records pushed by one process are invisible to the others.
- R10: Stack bounds are written through cfg_sel 2'b10 (base, which also moves the pointer to the base) and 2'b11 (limit), with cfg_idx as process number. At reset process p has base p*DEPTH, limit (p+1)*DEPTH and an empty stack.
- R11: When op_valid is low or op_kind is 2'b00, no out_valid, ent_valid or flt_valid pulse follows. At most one of the three pulses is high in any cycle.
- R12: After reset all pulses are low, out_pc is 0 and flt_code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request this cycle |
| op_kind | input | 2 | 00 none, 01 call, 10 entry, 11 return |
| cur_tid | input | TID_W | Thread number of the requester |
| cur_pid | input | PID_W | Process number of the requester; selects the stack |
| cur_cid | input | CID_W | Context number of the requester |
| ret_pc | input | ADDR_W | Address to resume at after the call returns |
| tgt_addr | input | ADDR_W | Call target address |
| tgt_cid | input | CID_W | Call target context |
| tgt_opcode | input | OP_W | Instruction word fetched at the target |
| cfg_we | input | 1 | Bound register write strobe |
| cfg_sel | input | 2 | 00 window lo, 01 window hi, 10 stack base, 11 stack limit |
| cfg_idx | input | CID_W | Context or process number for the write |
| cfg_data | input | ADDR_W | Value written |
| out_valid | output | 1 | Redirect pulse after a call or return |
| out_pc | output | ADDR_W | Next PC |
| out_cid | output | CID_W | Next context |
| out_tid | output | TID_W | Thread of the resumed or calling code |
| out_pid | output | PID_W | Process of the resumed or calling code |
| ent_valid | output | 1 | Entry handshake result pulse |
| ent_tid | output | TID_W | Caller thread seen by the entry |
| ent_pid | output | PID_W | Caller process seen by the entry |
| flt_valid | output | 1 | Fault pulse |
| flt_code | output | 2 | Last fault code |

## Verification
The hardest state to reach from the ports is a full stack whose pointer sits exactly at its limit, combined with a refused call. After that refusal the pointer must not have moved, and only later pops can show this. The stimulus fills one process stack with distinct records, provokes the overflow, and then unwinds the stack. Checking every popped record in order, and then the underflow at the base, shows the refused call left no trace. Window edges are swept address by address around both bounds, and single-bit corruptions of the entry opcode are swept across all sixteen bits.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_CALL  = 2'b01,
        OP_ENTRY = 2'b10,
        OP_RET   = 2'b11
    } ccu_op_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_WINDOW = 2'b01,
        FLT_ENTRY  = 2'b10,
        FLT_STACK  = 2'b11
    } ccu_flt_e;

    typedef enum logic [1:0] {
        CFG_WIN_LO   = 2'b00,
        CFG_WIN_HI   = 2'b01,
        CFG_STK_BASE = 2'b10,
        CFG_STK_LIM  = 2'b11
    } ccu_cfg_e;
endpackage

// File: rtl/ccu_window_bank.sv
module ccu_window_bank #(
    parameter int ADDR_W = 16,
    parameter int CID_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [CID_W-1:0]  wr_cid,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic [CID_W-1:0]  chk_cid,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              in_win
);
    localparam int NCTX = 1 << CID_W;

    typedef struct packed {
        logic [NCTX-1:0][ADDR_W-1:0] lo;
        logic [NCTX-1:0][ADDR_W-1:0] hi;
    } win_t;

    win_t win_d, win_q;
    logic [NCTX-1:0] hit;

    always_comb begin
        win_d = win_q;
        if (wr_lo) win_d.lo[wr_cid] = wr_val;
        if (wr_hi) win_d.hi[wr_cid] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q.lo <= '0;
            win_q.hi <= '1;
        end else begin
            win_q <= win_d;
        end
    end

    // one inclusive comparator pair per context
    for (genvar c = 0; c < NCTX; c++) begin : g_cmp
        assign hit[c] = (chk_addr >= win_q.lo[c]) && (chk_addr <= win_q.hi[c]);
    end

    assign in_win = hit[chk_cid];
endmodule

// File: rtl/ccu_ret_stack.sv
module ccu_ret_stack #(
    parameter int PID_W = 2,
    parameter int DEPTH = 4,
    parameter int REC_W = 24,
    localparam int NPROC = 1 << PID_W,
    localparam int SLOTS = NPROC * DEPTH,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PTR_W = SLOT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PID_W-1:0] sel_pid,
    input  logic             push,
    input  logic             pop,
    input  logic [REC_W-1:0] push_rec,
    input  logic             wr_base,
    input  logic             wr_lim,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [PTR_W-1:0] wr_val,
    output logic             full,
    output logic             empty,
    output logic [REC_W-1:0] top_rec
);
    typedef struct packed {
        logic [NPROC-1:0][PTR_W-1:0] ptr;
        logic [NPROC-1:0][PTR_W-1:0] base;
        logic [NPROC-1:0][PTR_W-1:0] lim;
    } stk_t;

    stk_t st_d, st_q;
    logic [REC_W-1:0]  rec_mem [SLOTS];
    logic [SLOT_W-1:0] wr_slot, rd_slot;

    assign full    = (st_q.ptr[sel_pid] == st_q.lim[sel_pid]);
    assign empty   = (st_q.ptr[sel_pid] == st_q.base[sel_pid]);
    assign wr_slot = st_q.ptr[sel_pid][SLOT_W-1:0];
    assign rd_slot = st_q.ptr[sel_pid][SLOT_W-1:0] - SLOT_W'(1);
    assign top_rec = rec_mem[rd_slot];

    always_comb begin
        st_d = st_q;
        if (push)     st_d.ptr[sel_pid] = st_q.ptr[sel_pid] + PTR_W'(1);
        else if (pop) st_d.ptr[sel_pid] = st_q.ptr[sel_pid] - PTR_W'(1);
        if (wr_base) begin
            st_d.base[wr_pid] = wr_val;
            st_d.ptr[wr_pid]  = wr_val;
        end
        if (wr_lim) st_d.lim[wr_pid] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPROC; p++) begin
                st_q.ptr[p]  <= PTR_W'(p * DEPTH);
                st_q.base[p] <= PTR_W'(p * DEPTH);
                st_q.lim[p]  <= PTR_W'((p + 1) * DEPTH);
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) rec_mem[wr_slot] <= push_rec;
    end
endmodule

// File: rtl/ctx_call_unit.sv
module ctx_call_unit
    import ccu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TID_W  = 3,
    parameter int PID_W  = 2,
    parameter int CID_W  = 3,
    parameter int DEPTH  = 4,
    parameter int OP_W   = 16,
    parameter logic [OP_W-1:0] ENTRY_OP = 16'hE7A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [TID_W-1:0]  cur_tid,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic [CID_W-1:0]  cur_cid,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [CID_W-1:0]  tgt_cid,
    input  logic [OP_W-1:0]   tgt_opcode,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CID_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_pc,
    output logic [CID_W-1:0]  out_cid,
    output logic [TID_W-1:0]  out_tid,
    output logic [PID_W-1:0]  out_pid,
    output logic              ent_valid,
    output logic [TID_W-1:0]  ent_tid,
    output logic [PID_W-1:0]  ent_pid,
    output logic              flt_valid,
    output logic [1:0]        flt_code
);
    localparam int PTR_W = $clog2((1 << PID_W) * DEPTH) + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [TID_W-1:0]  tid;
        logic [PID_W-1:0]  pid;
        logic [CID_W-1:0]  cid;
    } rec_t;

    localparam int REC_W = $bits(rec_t);

    typedef struct packed {
        logic              ov;
        logic [ADDR_W-1:0] pc;
        logic [CID_W-1:0]  cid;
        logic [TID_W-1:0]  tid;
        logic [PID_W-1:0]  pid;
        logic              ev;
        logic [TID_W-1:0]  etid;
        logic [PID_W-1:0]  epid;
        logic              fv;
        logic [1:0]        fc;
    } out_t;

    out_t out_d, out_q;

    logic             in_win, stk_full, stk_empty;
    logic             do_push, do_pop;
    logic [REC_W-1:0] top_raw;
    rec_t             top, new_rec;
    logic             is_call, is_entry, is_ret;

    assign is_call  = op_valid && (op_kind == OP_CALL);
    assign is_entry = op_valid && (op_kind == OP_ENTRY);
    assign is_ret   = op_valid && (op_kind == OP_RET);

    assign new_rec = '{pc: ret_pc, tid: cur_tid, pid: cur_pid, cid: cur_cid};
    assign top     = rec_t'(top_raw);

    ccu_window_bank #(.ADDR_W(ADDR_W), .CID_W(CID_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (cfg_we && (cfg_sel == CFG_WIN_LO)),
        .wr_hi    (cfg_we && (cfg_sel == CFG_WIN_HI)),
        .wr_cid   (cfg_idx),
        .wr_val   (cfg_data),
        .chk_cid  (tgt_cid),
        .chk_addr (tgt_addr),
        .in_win   (in_win)
    );

    ccu_ret_stack #(.PID_W(PID_W), .DEPTH(DEPTH), .REC_W(REC_W)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_pid  (cur_pid),
        .push     (do_push),
        .pop      (do_pop),
        .push_rec (new_rec),
        .wr_base  (cfg_we && (cfg_sel == CFG_STK_BASE)),
        .wr_lim   (cfg_we && (cfg_sel == CFG_STK_LIM)),
        .wr_pid   (cfg_idx[PID_W-1:0]),
        .wr_val   (cfg_data[PTR_W-1:0]),
        .full     (stk_full),
        .empty    (stk_empty),
        .top_rec  (top_raw)
    );

    always_comb begin
        out_d    = out_q;
        out_d.ov = 1'b0;
        out_d.ev = 1'b0;
        out_d.fv = 1'b0;
        do_push  = 1'b0;
        do_pop   = 1'b0;

        if (is_call) begin
            // check order: window, then entry opcode, then stack room
            if (!in_win) begin
                out_d.fv = 1'b1;
                out_d.fc = FLT_WINDOW;
            end else if (tgt_opcode != ENTRY_OP) begin
                out_d.fv = 1'b1;
                out_d.fc = FLT_ENTRY;
            end else if (stk_full) begin
                out_d.fv = 1'b1;
                out_d.fc = FLT_STACK;
            end else begin
                do_push   = 1'b1;
                out_d.ov  = 1'b1;
                out_d.pc  = tgt_addr;
                out_d.cid = tgt_cid;
                out_d.tid = cur_tid;
                out_d.pid = cur_pid;
            end
        end else if (is_entry) begin
            if (stk_empty) begin
                out_d.fv = 1'b1;
                out_d.fc = FLT_STACK;
            end else begin
                out_d.ev   = 1'b1;
                out_d.etid = top.tid;
                out_d.epid = top.pid;
            end
        end else if (is_ret) begin
            if (stk_empty) begin
                out_d.fv = 1'b1;
                out_d.fc = FLT_STACK;
            end else begin
                do_pop    = 1'b1;
                out_d.ov  = 1'b1;
                out_d.pc  = top.pc;
                out_d.cid = top.cid;
                out_d.tid = top.tid;
                out_d.pid = top.pid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.ov;
    assign out_pc    = out_q.pc;
    assign out_cid   = out_q.cid;
    assign out_tid   = out_q.tid;
    assign out_pid   = out_q.pid;
    assign ent_valid = out_q.ev;
    assign ent_tid   = out_q.etid;
    assign ent_pid   = out_q.epid;
    assign flt_valid = out_q.fv;
    assign flt_code  = out_q.fc;
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
    parameter int ADDR_W = 16,
    parameter int CID_W  = 3,
    parameter int OP_W   = 16,
    parameter logic [OP_W-1:0] ENTRY_OP = 16'hE7A0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [OP_W-1:0]   tgt_opcode,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_pc,
    input logic [CID_W-1:0]  out_cid,
    input logic              ent_valid,
    input logic              flt_valid,
    input logic [1:0]        flt_code
);
    assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, ent_valid, flt_valid}));

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_kind != 2'b00) |=> !(out_valid || ent_valid || flt_valid));

    assert_call_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01) |=> (!out_valid || out_pc == $past(tgt_addr)));

    assert_needs_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01 && tgt_opcode != ENTRY_OP) |=> (flt_valid && flt_code != 2'b00));

    assert_hold_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ($stable(out_pc) && $stable(out_cid)));

    assert_entry_no_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b10) |=> !out_valid);
endmodule

bind ctx_call_unit ccu_checker #(
    .ADDR_W(ADDR_W), .CID_W(CID_W), .OP_W(OP_W), .ENTRY_OP(ENTRY_OP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .tgt_addr   (tgt_addr),
    .tgt_opcode (tgt_opcode),
    .out_valid  (out_valid),
    .out_pc     (out_pc),
    .out_cid    (out_cid),
    .ent_valid  (ent_valid),
    .flt_valid  (flt_valid),
    .flt_code   (flt_code)
);

// File: tb/sim_ctx_call_unit.sv
module sim_ctx_call_unit;
    localparam int CLK_P = 10;
    localparam logic [15:0] ENTRY = 16'hE7A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [2:0]  cur_tid = '0;
    logic [1:0]  cur_pid = '0;
    logic [2:0]  cur_cid = '0;
    logic [15:0] ret_pc = '0;
    logic [15:0] tgt_addr = '0;
    logic [2:0]  tgt_cid = '0;
    logic [15:0] tgt_opcode = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_data = '0;
    logic        out_valid, ent_valid, flt_valid;
    logic [15:0] out_pc;
    logic [2:0]  out_cid, out_tid, ent_tid;
    logic [1:0]  out_pid, ent_pid, flt_code;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    ctx_call_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .cur_tid(cur_tid), .cur_pid(cur_pid), .cur_cid(cur_cid), .ret_pc(ret_pc),
        .tgt_addr(tgt_addr), .tgt_cid(tgt_cid), .tgt_opcode(tgt_opcode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_pc(out_pc), .out_cid(out_cid), .out_tid(out_tid),
        .out_pid(out_pid), .ent_valid(ent_valid), .ent_tid(ent_tid), .ent_pid(ent_pid),
        .flt_valid(flt_valid), .flt_code(flt_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, release at the next; outputs are then settled
    task automatic op(input bit v, input logic [1:0] k, input logic [2:0] tid,
                      input logic [1:0] pid, input logic [2:0] cid, input logic [15:0] rpc,
                      input logic [15:0] ta, input logic [2:0] tc, input logic [15:0] opc);
        @(negedge clk);
        op_valid = v; op_kind = k; cur_tid = tid; cur_pid = pid; cur_cid = cid;
        ret_pc = rpc; tgt_addr = ta; tgt_cid = tc; tgt_opcode = opc;
        @(negedge clk);
        op_valid = 1'b0; op_kind = 2'b00;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [2:0] idx, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R12 watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] t;
        logic [15:0] last_pc;
        bit inw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 pulses", {out_valid, ent_valid, flt_valid}, 3'b000);
        chk("R12 out_pc", out_pc, 16'h0);
        chk("R12 flt_code", flt_code, 2'b00);

        // R2/R1/R6 window sweep on context 5, window 0x0100..0x01FF
        cfg(2'b00, 3'd5, 16'h0100);
        cfg(2'b01, 3'd5, 16'h01FF);
        last_pc = 16'h0;
        for (int i = 0; i < 32; i++) begin
            t = (i < 16) ? 16'h00F8 + 16'(i) : 16'h01F8 + 16'(i - 16);
            inw = (t >= 16'h0100) && (t <= 16'h01FF);
            op(1, 2'b01, 3'd1, 2'd0, 3'd2, 16'h4000 + 16'(i), t, 3'd5, ENTRY);
            if (inw) begin
                chk("R1 valid", out_valid, 1'b1);
                chk("R1 pc", out_pc, t);
                chk("R1 cid", out_cid, 3'd5);
                chk("R1 tid/pid", {out_tid, out_pid}, {3'd1, 2'd0});
                op(1, 2'b11, 3'd1, 2'd0, 3'd5, 16'h0, 16'h0, 3'd0, 16'h0);
                chk("R6 pc", out_pc, 16'h4000 + 16'(i));
                chk("R6 cid", out_cid, 3'd2);
                last_pc = 16'h4000 + 16'(i);
            end else begin
                chk("R2 fault", {flt_valid, flt_code}, 3'b101);
                chk("R5 pc held", out_pc, last_pc);
            end
        end

        // R3 single-bit corrupted opcodes inside the window
        for (int b = 0; b < 16; b++) begin
            op(1, 2'b01, 3'd1, 2'd0, 3'd2, 16'h4444, 16'h0140, 3'd5, ENTRY ^ (16'h1 << b));
            chk("R3 bad opcode", {flt_valid, flt_code, out_valid}, 4'b1100);
        end
        op(1, 2'b01, 3'd1, 2'd0, 3'd2, 16'h4444, 16'h0300, 3'd5, 16'h0000);
        chk("R3 window first", {flt_valid, flt_code}, 3'b101);

        // R4/R5/R6/R7/R8 fill process 1 (depth 4)
        for (int i = 0; i < 4; i++) begin
            op(1, 2'b01, 3'(i), 2'd1, 3'(i), 16'h2000 + 16'(i), 16'h0800 + 16'(16 * i), 3'd0, ENTRY);
            chk("R1 fill valid", out_valid, 1'b1);
            chk("R1 fill tid", out_tid, 3'(i));
        end
        op(1, 2'b01, 3'd7, 2'd1, 3'd7, 16'h2999, 16'h0900, 3'd0, ENTRY);
        chk("R4 overflow", {flt_valid, flt_code}, 3'b111);
        chk("R5 pc held", out_pc, 16'h0830);
        op(1, 2'b10, 3'd0, 2'd1, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R8 entry valid", ent_valid, 1'b1);
        chk("R8 entry caller", {ent_tid, ent_pid}, {3'd3, 2'd1});
        chk("R8 pc unmoved", out_pc, 16'h0830);
        for (int i = 3; i >= 0; i--) begin
            op(1, 2'b11, 3'd0, 2'd1, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
            chk("R6 lifo pc", out_pc, 16'h2000 + 16'(i));
            chk("R6 lifo id", {out_cid, out_tid, out_pid}, {3'(i), 3'(i), 2'd1});
        end
        op(1, 2'b11, 3'd0, 2'd1, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R7 underflow", {flt_valid, flt_code}, 3'b111);

        // R9 stacks are per process
        op(1, 2'b01, 3'd5, 2'd2, 3'd6, 16'h3333, 16'h0500, 3'd0, ENTRY);
        chk("R9 push p2", out_valid, 1'b1);
        op(1, 2'b11, 3'd0, 2'd3, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R9 p3 empty", {flt_valid, flt_code}, 3'b111);
        op(1, 2'b10, 3'd0, 2'd3, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R8 entry empty", {flt_valid, flt_code, ent_valid}, 4'b1110);
        op(1, 2'b10, 3'd0, 2'd2, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R8 entry p2", {ent_valid, ent_tid, ent_pid}, {1'b1, 3'd5, 2'd2});
        op(1, 2'b11, 3'd0, 2'd2, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R9 pop p2", {out_valid, out_pc, out_cid, out_tid}, {1'b1, 16'h3333, 3'd6, 3'd5});

        // R10 rewrite stack bounds of process 0
        cfg(2'b11, 3'd0, 16'd1);
        op(1, 2'b01, 3'd2, 2'd0, 3'd1, 16'h5000, 16'h0600, 3'd0, ENTRY);
        chk("R10 one slot", out_valid, 1'b1);
        op(1, 2'b01, 3'd2, 2'd0, 3'd1, 16'h5001, 16'h0604, 3'd0, ENTRY);
        chk("R10 new limit", {flt_valid, flt_code}, 3'b111);
        cfg(2'b10, 3'd0, 16'd0);
        op(1, 2'b11, 3'd0, 2'd0, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R10 base resets ptr", {flt_valid, flt_code}, 3'b111);
        cfg(2'b11, 3'd0, 16'd4);
        op(1, 2'b01, 3'd2, 2'd0, 3'd1, 16'h5002, 16'h0608, 3'd0, ENTRY);
        op(1, 2'b01, 3'd2, 2'd0, 3'd1, 16'h5003, 16'h060C, 3'd0, ENTRY);
        chk("R10 restored", out_valid, 1'b1);
        op(1, 2'b11, 3'd0, 2'd0, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R10 pop", out_pc, 16'h5003);

        // R11 idle requests
        op(1, 2'b00, 3'd1, 2'd0, 3'd1, 16'h7777, 16'h0700, 3'd0, ENTRY);
        chk("R11 kind none", {out_valid, ent_valid, flt_valid}, 3'b000);
        op(0, 2'b01, 3'd1, 2'd0, 3'd1, 16'h7777, 16'h0700, 3'd0, ENTRY);
        chk("R11 no valid", {out_valid, ent_valid, flt_valid}, 3'b000);
        chk("R11 pc held", out_pc, 16'h5003);
        op(1, 2'b11, 3'd0, 2'd0, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
        chk("R11 nothing pushed", out_pc, 16'h5002);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule